// File: doc/BRIEF.md
# Transport stream timestamp counter

This block keeps a running system time, clocked by the 27 MHz time-base that also clocks the whole block. It also stamps incoming transport packets with that time. The time value has two parts: a 33-bit base and a 9-bit extension. In the default mode the extension is a modulo-300 counter whose wrap carries into the base, so the base advances at 90 kHz. With `direct_mode` set, the base counts every clock and the extension is frozen.

Packet bytes enter on a valid/ready byte stream. The block looks for a packet start, which is a byte equal to 0x47. When that sync byte is accepted, it takes a snapshot of the counter. It then forwards the `PKT_LEN` bytes of the packet and, after the last one, inserts the snapshot as a 6-byte timestamp into the outgoing byte stream that feeds a receive FIFO. Software can preload the counter and select the mode. Any comparison against received clock references happens elsewhere.

Top module: `ts_stamp_top`

## Requirements
- R1: After reset the counter is zero, `in_ready` is 1 and `out_valid` is 0. Counting starts on the first clock edge after reset is released.
- R2: With `direct_mode`=0, the extension steps 0..299 by one per clock and then returns to 0. On that return, the base goes up by one.
- R3: With `direct_mode`=1, the base goes up by one on every clock, the extension holds its value, and the extension field of every timestamp taken in this mode reads 0.
- R4: The base wraps from all ones to zero in either mode.
- R5: When `preload_en` is 1 at a clock edge, base and extension take `preload_base` and `preload_ext` at that edge instead of counting. Preloaded extension values are below 300.
- R6: The snapshot equals the counter value held in the cycle in which the sync byte is accepted.
- R7: The timestamp is 48 bits: base in bits 47:15, zeros in 14:9, extension in 8:0. It is sent as six bytes, bits 47:40 first and bits 7:0 last, after the last packet byte.
- R8: Each byte of a started packet appears on `out_data` with `out_valid`=1, in order, one cycle after it is accepted. Output bytes only ever come from packets and timestamps.
- R9: A byte other than 0x47 accepted while no packet is open is discarded, and the block keeps looking for a start byte by byte.
- R10: In the cycle after a packet's last byte is accepted, `in_ready` is still 1. It is then 0 for exactly six cycles while the timestamp goes out, and 1 again after that.
- R11: If a sync byte is accepted while a timestamp is still waiting to go out, that packet's `PKT_LEN` bytes are all discarded and the earlier snapshot is the one emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz time-base; clocks the whole block |
| rst_n | input | 1 | Active-low synchronous reset |
| direct_mode | input | 1 | 0: base/extension counting; 1: base counts every clock |
| preload_en | input | 1 | Load counter from preload values at this edge |
| preload_base | input | 33 | Base value to load |
| preload_ext | input | 9 | Extension value to load |
| in_valid | input | 1 | Upstream byte valid |
| in_data | input | 8 | Upstream byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Packet or timestamp byte toward receive FIFO |

## Verification
The counter is swept over a grid of preload points in both modes. The extension is placed at 0, in the middle, just before and at the wrap, and the base is placed near its top. Sync bytes arrive after varying delays, so the snapshots show whether the carry, the frozen extension and the 33-bit wrap land on the correct clock. Streams of noise bytes ahead of a packet separate start-byte hunting from forwarding. A packet that begins in the one open cycle right after a packet end checks the discard rule and the six-cycle ready gap.

// File: rtl/ts_stamp_pkg.sv
package ts_stamp_pkg;
  localparam int BASE_W      = 33;
  localparam int EXT_W       = 9;
  localparam int STAMP_W     = 48;
  localparam int STAMP_BYTES = STAMP_W / 8;
  localparam int RSV_W       = STAMP_W - BASE_W - EXT_W;
  localparam int SIDX_W      = $clog2(STAMP_BYTES);

  typedef logic [BASE_W-1:0]  base_t;
  typedef logic [EXT_W-1:0]   ext_t;
  typedef logic [STAMP_W-1:0] stamp_t;
  typedef logic [SIDX_W-1:0]  sidx_t;

  typedef enum logic [1:0] {
    FR_HUNT = 2'd0,
    FR_PASS = 2'd1,
    FR_SKIP = 2'd2
  } fr_state_e;

  // Assemble the 48-bit timestamp word; extension is blanked in direct mode.
  function automatic stamp_t pack_stamp(base_t b, ext_t e, logic direct);
    ext_t e_use;
    e_use = direct ? ext_t'(0) : e;
    return {b, {RSV_W{1'b0}}, e_use};
  endfunction

  // Byte i of the timestamp, most significant byte first.
  function automatic logic [7:0] stamp_byte(stamp_t s, sidx_t i);
    return s[8*(STAMP_BYTES-1-int'(i)) +: 8];
  endfunction
endpackage

// File: rtl/ts_time_base.sv
module ts_time_base
  import ts_stamp_pkg::*;
#(
  parameter int EXT_MOD = 300
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  direct,
  input  logic  load,
  input  base_t load_base,
  input  ext_t  load_ext,
  output base_t base_o,
  output ext_t  ext_o,
  output logic  ext_wrap_o
);
  localparam ext_t EXT_LAST = ext_t'(EXT_MOD - 1);

  base_t base_q;
  ext_t  ext_q;

  assign ext_wrap_o = !direct && (ext_q >= EXT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      ext_q  <= '0;
    end else if (load) begin
      base_q <= load_base;
      ext_q  <= load_ext;
    end else if (direct) begin
      base_q <= base_q + base_t'(1);
    end else if (ext_wrap_o) begin
      ext_q  <= '0;
      base_q <= base_q + base_t'(1);
    end else begin
      ext_q  <= ext_q + ext_t'(1);
    end
  end

  assign base_o = base_q;
  assign ext_o  = ext_q;

  AST_EXT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !direct) |=> (ext_q < ext_t'(EXT_MOD))); // R2
  AST_DIRECT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && direct) |=> (base_q == $past(base_q) + base_t'(1)) && $stable(ext_q)); // R3
  AST_BASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && direct && (base_q == '1)) |=> (base_q == '0)); // R4
  AST_PRELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (base_q == $past(load_base)) && (ext_q == $past(load_ext))); // R5
endmodule

// File: rtl/ts_pkt_framer.sv
module ts_pkt_framer
  import ts_stamp_pkg::*;
#(
  parameter int         PKT_LEN   = 188,
  parameter logic [7:0] SYNC_BYTE = 8'h47
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       fwd_valid,
  output logic       snap_take,
  output logic       emit_act,
  output sidx_t      emit_idx,
  output logic       pend_o
);
  localparam int              CNT_W    = $clog2(PKT_LEN);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PKT_LEN - 1);
  localparam sidx_t           ELAST    = sidx_t'(STAMP_BYTES - 1);

  fr_state_e        st_q;
  logic [CNT_W-1:0] idx_q;
  logic             rdy_q;
  logic             pend_q;
  sidx_t            eidx_q;

  logic accept, is_sync, at_last, start_ok, start_skip, pass_byte, pkt_end, emit_end;

  assign accept     = in_valid && rdy_q;
  assign is_sync    = (in_data == SYNC_BYTE);
  assign at_last    = (idx_q == LAST_IDX);
  assign start_ok   = accept && (st_q == FR_HUNT) && is_sync && !pend_q;
  assign start_skip = accept && (st_q == FR_HUNT) && is_sync && pend_q;
  assign pass_byte  = accept && (st_q == FR_PASS);
  assign pkt_end    = pass_byte && at_last;
  assign emit_act   = pend_q && !rdy_q;
  assign emit_end   = emit_act && (eidx_q == ELAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= FR_HUNT;
      idx_q  <= '0;
      rdy_q  <= 1'b1;
      pend_q <= 1'b0;
      eidx_q <= '0;
    end else begin
      // ready is a flop: it drops one cycle after a stamp becomes pending
      rdy_q <= !(pend_q && !emit_end);
      if (pkt_end)       pend_q <= 1'b1;
      else if (emit_end) pend_q <= 1'b0;
      if (emit_end)      eidx_q <= '0;
      else if (emit_act) eidx_q <= eidx_q + sidx_t'(1);
      case (st_q)
        FR_HUNT: begin
          if (start_ok) begin
            st_q  <= FR_PASS;
            idx_q <= CNT_W'(1);
          end else if (start_skip) begin
            st_q  <= FR_SKIP;
            idx_q <= CNT_W'(1);
          end
        end
        default: begin
          if (accept) begin
            if (at_last) begin
              st_q  <= FR_HUNT;
              idx_q <= '0;
            end else begin
              idx_q <= idx_q + CNT_W'(1);
            end
          end
        end
      endcase
    end
  end

  assign in_ready  = rdy_q;
  assign fwd_valid = start_ok || pass_byte;
  assign snap_take = start_ok;
  assign emit_idx  = eidx_q;
  assign pend_o    = pend_q;

  AST_EMIT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_act && !emit_end) |=> emit_act); // R10
  AST_READY_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> (in_ready && pend_o)); // R10
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FR_SKIP) |-> !snap_take); // R11
endmodule

// File: rtl/ts_stamp_emit.sv
module ts_stamp_emit
  import ts_stamp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       snap_take,
  input  base_t      cur_base,
  input  ext_t       cur_ext,
  input  logic       direct,
  input  sidx_t      emit_idx,
  output stamp_t     snap_o,
  output logic [7:0] byte_o
);
  stamp_t snap_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         snap_q <= '0;
    else if (snap_take) snap_q <= pack_stamp(cur_base, cur_ext, direct);
  end

  assign snap_o = snap_q;
  assign byte_o = stamp_byte(snap_q, emit_idx);
endmodule

// File: rtl/ts_stamp_top.sv
module ts_stamp_top
  import ts_stamp_pkg::*;
#(
  parameter int         PKT_LEN   = 188,
  parameter logic [7:0] SYNC_BYTE = 8'h47,
  parameter int         EXT_MOD   = 300
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        direct_mode,
  input  logic        preload_en,
  input  logic [32:0] preload_base,
  input  logic [8:0]  preload_ext,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        out_valid,
  output logic [7:0]  out_data
);
  base_t      cnt_base;
  ext_t       cnt_ext;
  logic       ext_wrap;
  logic       fwd_valid, snap_take, emit_act, pend;
  sidx_t      emit_idx;
  stamp_t     snap;
  logic [7:0] stamp_b;
  logic       ov_q;
  logic [7:0] od_q;

  ts_time_base #(.EXT_MOD(EXT_MOD)) u_cnt (
    .clk(clk), .rst_n(rst_n), .direct(direct_mode), .load(preload_en),
    .load_base(preload_base), .load_ext(preload_ext),
    .base_o(cnt_base), .ext_o(cnt_ext), .ext_wrap_o(ext_wrap)
  );

  ts_pkt_framer #(.PKT_LEN(PKT_LEN), .SYNC_BYTE(SYNC_BYTE)) u_frm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .fwd_valid(fwd_valid), .snap_take(snap_take),
    .emit_act(emit_act), .emit_idx(emit_idx), .pend_o(pend)
  );

  ts_stamp_emit u_emit (
    .clk(clk), .rst_n(rst_n), .snap_take(snap_take), .cur_base(cnt_base),
    .cur_ext(cnt_ext), .direct(direct_mode), .emit_idx(emit_idx),
    .snap_o(snap), .byte_o(stamp_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      od_q <= '0;
    end else begin
      ov_q <= fwd_valid || emit_act;
      od_q <= emit_act ? stamp_b : in_data;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;

  AST_WRAP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_wrap && !preload_en) |=> (cnt_base == $past(cnt_base) + base_t'(1)) && (cnt_ext == '0)); // R2
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> !emit_act); // R8
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> $stable(snap)); // R11
endmodule

// File: tb/ts_stamp_top_tb.sv
module ts_stamp_top_tb_top;
  localparam int         CLK_PERIOD = 38;
  localparam int         PL         = 8;
  localparam logic [7:0] SYNC       = 8'h47;
  localparam longint     BMOD       = 64'h2_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        direct_mode = 1'b0;
  logic        preload_en = 1'b0;
  logic [32:0] preload_base = '0;
  logic [8:0]  preload_ext = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid;
  logic [7:0]  out_data;

  ts_stamp_top #(.PKT_LEN(PL), .SYNC_BYTE(SYNC), .EXT_MOD(300)) dut_i (
    .clk(clk), .rst_n(rst_n), .direct_mode(direct_mode), .preload_en(preload_en),
    .preload_base(preload_base), .preload_ext(preload_ext), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  longint bm = 0, em = 0;
  int st_m = 0, idx_m = 0;
  bit pend_m = 1'b0, low_seen = 1'b0;
  logic [47:0] stamp_m;
  logic [7:0] exp_q[$];
  string tag_q[$];
  string cur_tag = "R1";

  task automatic check(input string tag, input longint got, input longint exp, input string what);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int seed, input int i);
    logic [7:0] r;
    r = 8'(seed * 29 + i * 13 + 5);
    if (r == SYNC) r = 8'h48;
    return r;
  endfunction

  // Counter model: a single running total in units of 27 MHz ticks.
  task automatic adv();
    longint tot;
    if (direct_mode) bm = (bm + 1) % BMOD;
    else begin
      tot = bm * 300 + em + 1;
      bm = (tot / 300) % BMOD;
      em = tot % 300;
    end
  endtask

  task automatic model_accept(input logic [7:0] d);
    case (st_m)
      0: if (d == SYNC) begin
           idx_m = 1;
           if (!pend_m) begin
             stamp_m = 48'(bm) << 15;
             if (!direct_mode) stamp_m = stamp_m | 48'(em);
             exp_q.push_back(d); tag_q.push_back("R8");
             st_m = 1;
           end else st_m = 2;
         end
      1: begin
           exp_q.push_back(d); tag_q.push_back("R8");
           if (idx_m == PL - 1) begin
             for (int k = 0; k < 6; k++) begin
               exp_q.push_back(stamp_m[8*(5-k) +: 8]);
               tag_q.push_back(cur_tag);
             end
             pend_m = 1'b1; st_m = 0; idx_m = 0;
           end else idx_m++;
         end
      default: begin
           if (idx_m == PL - 1) begin st_m = 0; idx_m = 0; end
           else idx_m++;
         end
    endcase
  endtask

  task automatic step(input bit v, input logic [7:0] d, input bit pl, output bit acc);
    logic [7:0] e;
    string t;
    if (!in_ready) low_seen = 1'b1;
    else if (low_seen) begin pend_m = 1'b0; low_seen = 1'b0; end
    in_valid = v; in_data = d; preload_en = pl;
    acc = v && in_ready;
    if (acc) model_accept(d);
    @(posedge clk);
    @(negedge clk);
    if (pl) begin bm = longint'(preload_base); em = longint'(preload_ext); end
    else adv();
    if (out_valid) begin
      if (exp_q.size() == 0) check(cur_tag, 1, 0, "unexpected output byte");
      else begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(t, out_data, e, "stream byte");
      end
    end
    in_valid = 1'b0; preload_en = 1'b0;
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, acc);
  endtask

  task automatic send_pkt(input bit good, input int seed);
    bit acc;
    logic [7:0] b;
    for (int i = 0; i < PL; i++) begin
      b = (i == 0) ? (good ? SYNC : 8'h3c) : pay(seed, i);
      acc = 1'b0;
      while (!acc) step(1'b1, b, 1'b0, acc);
    end
  endtask

  task automatic preload(input longint b, input int e);
    bit acc;
    preload_base = 33'(b); preload_ext = 9'(e);
    step(1'b0, 8'h00, 1'b1, acc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog expired: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    longint bases[3];
    int exts[4];
    bit acc;
    bases[0] = 0; bases[1] = 777; bases[2] = BMOD - 2;
    exts[0] = 0; exts[1] = 150; exts[2] = 296; exts[3] = 299;

    repeat (3) @(negedge clk);
    check("R1", in_ready, 1, "in_ready in reset");
    check("R1", out_valid, 0, "out_valid in reset");
    rst_n = 1'b1;
    bm = 0; em = 0;
    check("R1", in_ready, 1, "in_ready after reset");

    // R1: first stamp counts from zero
    cur_tag = "R1"; idle(5); send_pkt(1'b1, 1); idle(8);

    // R10: ready gap after packet end
    cur_tag = "R10"; send_pkt(1'b1, 2);
    check("R10", in_ready, 1, "ready in cycle after last byte");
    for (int k = 0; k < 6; k++) begin
      step(1'b0, 8'h00, 1'b0, acc);
      check("R10", in_ready, 0, "ready during stamp output");
    end
    step(1'b0, 8'h00, 1'b0, acc);
    check("R10", in_ready, 1, "ready after stamp output");
    idle(3);

    // R9: noise ahead of a packet is dropped
    cur_tag = "R9"; send_pkt(1'b0, 3); send_pkt(1'b0, 4); idle(2); send_pkt(1'b1, 5); idle(8);

    // R11: sync in the open cycle after a packet end
    cur_tag = "R11"; send_pkt(1'b1, 6); send_pkt(1'b1, 7); idle(8); send_pkt(1'b1, 8); idle(8);

    // R7: known layout, sync one cycle after preload
    cur_tag = "R7"; direct_mode = 1'b0; preload(64'h1_2345_6789, 9'h1AB);
    send_pkt(1'b1, 9); idle(8);

    // R5: preload replaces the running count
    cur_tag = "R5"; idle(17); preload(100, 5); idle(3); send_pkt(1'b1, 10); idle(8);

    // R4: base wrap in both modes
    cur_tag = "R4"; direct_mode = 1'b0; preload(BMOD - 1, 299); idle(1); send_pkt(1'b1, 11); idle(8);
    direct_mode = 1'b1; preload(BMOD - 1, 7); send_pkt(1'b1, 12); idle(8);
    direct_mode = 1'b1; preload(BMOD - 2, 0); idle(1); send_pkt(1'b1, 13); idle(8);

    // R6: snapshot time with varied lead-in
    cur_tag = "R6"; direct_mode = 1'b0;
    for (int g = 0; g < 5; g++) begin idle(g); send_pkt(1'b1, 20 + g); idle(8); end

    // R2 / R3 sweep over preload points, modes and sync delays
    for (int m = 0; m < 2; m++)
      for (int bi = 0; bi < 3; bi++)
        for (int ei = 0; ei < 4; ei++) begin
          direct_mode = m[0];
          cur_tag = (m == 0) ? "R2" : "R3";
          preload(bases[bi], exts[ei]);
          idle(ei); send_pkt(1'b1, m * 100 + bi * 10 + ei); idle(8);
          idle(bi); send_pkt(1'b1, m * 100 + bi * 10 + ei + 50); idle(8);
        end

    idle(10);
    check("R7", exp_q.size(), 0, "expected bytes still outstanding");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule